// File: doc/BRIEF.md
# Serial Port Register and Interrupt Block

This block is the register front end of a byte-wide serial port. A processor reaches it over a simple 32-bit register bus with single-cycle requests and registered read data. It holds transmit and receive control words, a transmit data register, a combined receive status/data word, and an interrupt register set that drives one interrupt line. Bytes leave on a valid/ready transmit interface and arrive on a valid/ready receive interface; the serializer and the baud logic live outside this block.

The receive status word can be read two ways. One offset clears the data-available flag as a side effect of the read. The other returns the same word and leaves everything unchanged. Interrupt sources latch into a raw register. A mask selects which of them reach the line. Writing ones to the acknowledge offset clears the matching raw bits, and the acknowledge offset always reads back zero.

Top module: `serial_regblk`

## Requirements
- R1: After reset, the status word reads 0x0140_0000 (transmitter ready and idle set), every other register reads zero, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: Offsets on `bus_addr` are: transmit control 0x000, transmit DMA enable 0x004, receive control 0x008, transmit data 0x01C (write only), status with clear 0x020, status without clear 0x024, mask 0x02C, acknowledge 0x030, raw interrupt 0x034, masked interrupt 0x038. The three control words and the mask read back what was written. Reads of any other offset return zero. Writes to other offsets, or to read-only offsets, change nothing.
- R3: A read request in one cycle produces `rd_valid` high with `rd_data` in the following cycle.
- R4: The status word carries the last received byte in bits 7:0, data-available in bit 16, transmitter idle in bit 22 and transmitter ready in bit 24. Both transmitter bits are low while a transmit byte is pending.
- R5: A read of 0x020 returns the status word and then clears data-available. A read of 0x024 changes nothing.
- R6: A write to 0x01C while no byte is pending raises `tx_valid` with `tx_data` equal to write data bits 7:0. It also sets raw interrupt bit 0. The byte is held until `tx_ready` is seen high.
- R7: A write to 0x01C while a byte is pending is dropped: `tx_data` is unchanged.
- R8: A received byte accepted on `rx_valid` and `rx_ready` is stored in status bits 7:0, sets data-available, and sets raw interrupt bit 3.
- R9: `rx_ready` is high when receive control bit 0 is set or raw interrupt bit 3 is clear. A byte offered while `rx_ready` is low is not stored.
- R10: A write to 0x030 clears every raw bit at a position where the write data is one. Reads of 0x030 return zero.
- R11: The masked register reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R12: A hardware set beats a same-cycle acknowledge of the same raw bit. A receive in the same cycle as a 0x020 read leaves data-available set, and that read returns the word as it was before the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can collide in a single cycle. The first pair is the receive path setting raw bit 3 and an acknowledge write clearing it. The second pair is the receive path setting data-available and a clearing status read removing it. The bench provokes each pair by driving the bus request and `rx_valid` on the same clock edge, with receive control bit 0 set so that the byte is accepted. It judges the result with side-effect-free reads afterwards: raw bit 3 and data-available must both still be set, and the clearing read must return the word as it stood before the new byte.

// File: rtl/serial_regblk.sv
module serial_regblk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TXCTL = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_DMAEN = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] A_RXCTL = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_TXDAT = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] A_STCLR = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_STPEK = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'('h02C);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] A_MSKD  = ADDR_W'('h038);
  localparam int B_DAV  = 16;
  localparam int B_IDLE = 22;
  localparam int B_RDY  = 24;
  localparam int I_TX   = 0;
  localparam int I_RX   = 3;

  logic [DATA_W-1:0] tx_ctl, dma_en, rx_ctl, mask, raw;
  logic [BYTE_W-1:0] rx_byte;
  logic              dav, tx_pend;
  logic [DATA_W-1:0] status, masked, rd_mux, set_v, ack_v;

  wire wr     = bus_valid & bus_write;
  wire rd     = bus_valid & ~bus_write;
  wire tx_go  = wr && bus_addr == A_TXDAT && !tx_pend;
  wire rx_acc = rx_valid & rx_ready;

  assign rx_ready = rx_ctl[0] | ~raw[I_RX];
  assign tx_valid = tx_pend;
  assign masked   = raw & mask;
  assign irq      = |masked;
  assign ack_v    = (wr && bus_addr == A_ACK) ? bus_wdata : '0;

  always_comb begin
    status = '0;
    status[BYTE_W-1:0] = rx_byte;
    status[B_DAV]  = dav;
    status[B_IDLE] = ~tx_pend;
    status[B_RDY]  = ~tx_pend;
    set_v = '0;
    set_v[I_TX] = tx_go;
    set_v[I_RX] = rx_acc;
  end

  always_comb begin
    case (bus_addr)
      A_TXCTL:          rd_mux = tx_ctl;
      A_DMAEN:          rd_mux = dma_en;
      A_RXCTL:          rd_mux = rx_ctl;
      A_STCLR, A_STPEK: rd_mux = status;
      A_MASK:           rd_mux = mask;
      A_RAW:            rd_mux = raw;
      A_MSKD:           rd_mux = masked;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ctl   <= '0;
      dma_en   <= '0;
      rx_ctl   <= '0;
      mask     <= '0;
      raw      <= '0;
      rx_byte  <= '0;
      dav      <= 1'b0;
      tx_pend  <= 1'b0;
      tx_data  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr && bus_addr == A_TXCTL) tx_ctl <= bus_wdata;
      if (wr && bus_addr == A_DMAEN) dma_en <= bus_wdata;
      if (wr && bus_addr == A_RXCTL) rx_ctl <= bus_wdata;
      if (wr && bus_addr == A_MASK)  mask   <= bus_wdata;
      raw <= (raw & ~ack_v) | set_v;
      if (tx_pend && tx_ready) tx_pend <= 1'b0;
      if (tx_go) begin
        tx_pend <= 1'b1;
        tx_data <= bus_wdata[BYTE_W-1:0];
      end
      if (rx_acc) begin
        rx_byte <= rx_data;
        dav     <= 1'b1;
      end else if (rd && bus_addr == A_STCLR) begin
        dav <= 1'b0;
      end
      rd_valid <= rd;
      rd_data  <= rd ? rd_mux : '0;
    end
  end

  p_rdlat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  p_txhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && wr && bus_addr == A_TXDAT |=> $stable(tx_data));
  p_rxset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> raw[I_RX] && status[B_DAV] && !rx_ready == !rx_ctl[0]);
  p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == A_STCLR && !rx_acc |=> !status[B_DAV]);
  p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == A_ACK && bus_wdata[I_RX] && !rx_acc |=> !raw[I_RX]);
  p_setwins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc && wr && bus_addr == A_ACK |=> raw[I_RX]);
  p_irqmask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask != '0 && raw != '0);
endmodule

// File: tb/serial_regblk_test.sv
module serial_regblk_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, tx_valid, rx_ready, irq;
  logic [31:0] rd_data;
  logic [7:0]  tx_data;
  logic        tx_ready = 0, rx_valid = 0;
  logic [7:0]  rx_data = '0;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  serial_regblk uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 1);
    rd(12'h024, 32'h0140_0000, "R1 R4 status reset");
    rd(12'h000, 0, "R1 txctl reset");
    rd(12'h034, 0, "R1 raw reset");
    rd(12'h02C, 0, "R1 mask reset");

    wr(12'h000, 32'hA5A5_0F0F);
    rd(12'h000, 32'hA5A5_0F0F, "R2 txctl readback");
    wr(12'h004, 32'h3);
    rd(12'h004, 32'h3, "R2 dma readback");
    wr(12'hFFC, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h034, 0, "R2 raw not writable");
    rd(12'h038, 0, "R2 masked not writable");
    rd(12'hFFC, 0, "R2 unmapped read zero");
    rd(12'h01C, 0, "R2 txdata reads zero");

    wr(12'h01C, 32'h1234_5642);
    check("R6 tx_valid", tx_valid, 1);
    check("R6 tx_data", tx_data, 8'h42);
    rd(12'h034, 32'h1, "R6 raw bit0");
    rd(12'h024, 32'h0, "R4 tx busy status");
    wr(12'h01C, 32'h77);
    check("R7 dropped write", tx_data, 8'h42);
    rd(12'h034, 32'h1, "R7 raw unchanged");
    check("R6 held", tx_valid, 1);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    check("R6 accepted", tx_valid, 0);
    rd(12'h024, 32'h0140_0000, "R4 tx idle again");

    wr(12'h02C, 32'h1);
    check("R11 irq on", irq, 1);
    rd(12'h038, 32'h1, "R11 masked");
    wr(12'h030, 32'h1);
    check("R10 irq off", irq, 0);
    rd(12'h034, 0, "R10 raw cleared");
    rd(12'h030, 0, "R10 ack reads zero");

    rx_valid = 1; rx_data = 8'h5A;
    @(negedge clk);
    rx_valid = 0;
    check("R9 rx_ready low", rx_ready, 0);
    rd(12'h024, 32'h0141_005A, "R8 R4 rx status");
    rd(12'h034, 32'h8, "R8 raw bit3");
    rx_valid = 1; rx_data = 8'h11;
    @(negedge clk);
    rx_valid = 0;
    rd(12'h024, 32'h0141_005A, "R9 byte refused");
    wr(12'h008, 32'h1);
    check("R9 rx_ready by ctl", rx_ready, 1);
    rd(12'h008, 32'h1, "R2 rxctl readback");

    rd(12'h020, 32'h0141_005A, "R5 clearing read");
    rd(12'h024, 32'h0140_005A, "R5 dav cleared");
    rd(12'h024, 32'h0140_005A, "R5 peek no effect");

    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 12'h030; bus_wdata = 32'h8;
    rx_valid = 1; rx_data = 8'h33;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; rx_valid = 0;
    rd(12'h034, 32'h8, "R12 set beats ack");
    rd(12'h024, 32'h0141_0033, "R12 rx during ack");
    wr(12'h030, 32'h8);
    rd(12'h034, 0, "R10 ack bit3");

    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 12'h020;
    exp_q.push_back(32'h0141_0033); tag_q.push_back("R12 clearing read old word");
    rx_valid = 1; rx_data = 8'h44;
    @(negedge clk);
    bus_valid = 0; rx_valid = 0;
    rd(12'h024, 32'h0141_0044, "R12 dav kept");

    wr(12'h02C, 32'h8);
    check("R11 irq bit3", irq, 1);
    rd(12'h038, 32'h8, "R11 masked bit3");
    wr(12'h02C, 32'h0);
    check("R11 irq masked off", irq, 0);
    rd(12'h038, 0, "R11 masked zero");
    rd(12'h034, 32'h8, "R11 raw kept");

    repeat (3) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule